// File: doc/BRIEF.md
# SMBus Notify Status and Line Control Registers

This block holds two byte-wide registers for an SMBus-style controller. The line control register lets software force the clock line low. It also returns the live levels of the clock and data lines, which are sampled into the bus clock domain. The notify status register records that the slave receiver has taken in a complete, successful Host Notify message. While that record stands, the block protects the captured notify address and data, and it tells the receiver to refuse the address byte of any further notify.

The status bit and the notify holding registers live in a slow clock domain of about 64 kHz, driven by the slave receiver. A software clear is written in the bus domain and crosses into the slow domain through a request/acknowledge toggle pair. It takes effect several slow cycles later, so software polls the status register until the change shows. Both domains share one asynchronous resume-well reset.

Top module: `smbn_notify_regs`

## Requirements
- R1: After reset the line control register reads with bit 2 = 1, `scl_force_low` is 0, the status register (offset 1) reads 00h, and `rx_ack_en` is 1.
- R2: A bus write to offset 0 with data bit 2 = 0 drives `scl_force_low` to 1 from the next bus clock. A write with bit 2 = 1 releases it. Written bits 7:3, 1 and 0 are ignored.
- R3: Line control bit 1 returns the data line level and bit 0 returns the clock line level, each through a two-flop synchroniser, so a level change shows on a read two bus clocks later. Bits 7:3 read 0.
- R4: A one-slow-cycle `rx_notify_done` pulse sets status bit 0. Reads at offset 1 then return 01h once the bit has been synchronised.
- R5: Writing 1 to status bit 0 clears it after the crossing. Writing 0 to it leaves it unchanged. Status bits 7:1 always read 0.
- R6: `rx_ack_en` is 0 from the slow clock edge that sets the status bit until the edge that clears it, and is 1 otherwise.
- R7: `notify_addr` and `notify_data` capture the receiver's values on a completed notify only while the status bit is 0. A notify completed while the bit is 1 leaves them unchanged.
- R8: When a completed notify and an arriving clear fall in the same slow cycle, the status bit stays 1.
- R9: Reads at offsets other than 0 and 1 return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| slow_clk | input | 1 | Slow status-domain clock (about 64 kHz) |
| rsm_rst_n | input | 1 | Asynchronous active-low resume-well reset |
| bus_wr | input | 1 | Register write strobe, one bus clock per write |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| scl_in | input | 1 | Clock line level from the pad |
| sda_in | input | 1 | Data line level from the pad |
| scl_force_low | output | 1 | 1 = pull the clock line low |
| rx_notify_done | input | 1 | Slow domain: a Host Notify completed successfully |
| rx_notify_addr | input | NADDR_W | Slow domain: address carried by the notify |
| rx_notify_data | input | NDATA_W | Slow domain: data carried by the notify |
| rx_ack_en | output | 1 | Slow domain: 1 = receiver may ACK a notify address byte |
| notify_addr | output | NADDR_W | Held notify address |
| notify_data | output | NDATA_W | Held notify data |

## Verification
A software clear of the status bit and a newly completed notify can land in the same slow clock cycle. Setting must win. The bench provokes this by holding `rx_notify_done` high across the whole window in which the clear request is in flight, so whichever slow cycle the clear arrives in also carries a set. It judges the result by watching `rx_ack_en` on every slow cycle of that window: it must never rise. It also checks that the status still reads 01h and that the held address did not change.

// File: rtl/smbn_pkg.sv
package smbn_pkg;
   localparam int BYTE_W       = 8;
   localparam int OFS_LINE     = 0;
   localparam int OFS_STATUS   = 1;
   localparam int BIT_CLK_OVR  = 2;
   localparam int BIT_SDA_LVL  = 1;
   localparam int BIT_SCL_LVL  = 0;
   localparam int BIT_NOTIFIED = 0;
   typedef logic [BYTE_W-1:0] reg_byte_t;
endpackage

// File: rtl/smbn_sync.sv
module smbn_sync #(
   parameter int               WIDTH   = 1,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   localparam int CHAIN_W = WIDTH * STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("smbn_sync: STAGES must be at least 2");
   end

   logic [CHAIN_W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[CHAIN_W-WIDTH-1:0], d};
   end

   assign q = chain_q[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/smbn_line_ctl.sv
module smbn_line_ctl
   import smbn_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_en,
   input  logic      wr_ovr_bit,
   input  logic      scl_pin,
   input  logic      sda_pin,
   output reg_byte_t rd_byte,
   output logic      scl_force_low
);
   logic       ovr_q;
   logic [1:0] lvl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ovr_q <= 1'b1;
      else if (wr_en) ovr_q <= wr_ovr_bit;
   end

   smbn_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_lvl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sda_pin, scl_pin}),
      .q     (lvl_s)
   );

   always_comb begin
      rd_byte              = '0;
      rd_byte[BIT_CLK_OVR] = ovr_q;
      rd_byte[BIT_SDA_LVL] = lvl_s[1];
      rd_byte[BIT_SCL_LVL] = lvl_s[0];
   end

   assign scl_force_low = ~ovr_q;
endmodule

// File: rtl/smbn_notify_sts.sv
module smbn_notify_sts #(
   parameter int SYNC_STAGES = 2,
   parameter int NADDR_W     = 7,
   parameter int NDATA_W     = 16
) (
   input  logic               bus_clk,
   input  logic               slow_clk,
   input  logic               rst_n,
   input  logic               clr_wr,
   input  logic               rx_done,
   input  logic [NADDR_W-1:0] rx_addr,
   input  logic [NDATA_W-1:0] rx_data,
   output logic               sts_bus,
   output logic               sts_q,
   output logic               clr_evt,
   output logic               ack_en,
   output logic [NADDR_W-1:0] hold_addr,
   output logic [NDATA_W-1:0] hold_data
);
   // bus side: request toggle, blocked while a previous request is in flight
   logic req_q, ack_bus, pending;
   assign pending = req_q ^ ack_bus;

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n)                  req_q <= 1'b0;
      else if (clr_wr && !pending) req_q <= ~req_q;
   end

   // slow side: edge of the synchronised request is the clear event
   logic req_slow, ack_q, sts_n;

   smbn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
      .clk (slow_clk), .rst_n (rst_n), .d (req_q), .q (req_slow)
   );

   assign clr_evt = req_slow ^ ack_q;
   assign sts_n   = rx_done | (sts_q & ~clr_evt);   // set wins over clear

   always_ff @(posedge slow_clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         sts_q     <= 1'b0;
         ack_en    <= 1'b1;
         hold_addr <= '0;
         hold_data <= '0;
      end else begin
         ack_q  <= req_slow;
         sts_q  <= sts_n;
         ack_en <= ~sts_n;
         if (rx_done && !sts_q) begin
            hold_addr <= rx_addr;
            hold_data <= rx_data;
         end
      end
   end

   smbn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk (bus_clk), .rst_n (rst_n), .d (ack_q), .q (ack_bus)
   );

   smbn_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sts_sync (
      .clk (bus_clk), .rst_n (rst_n), .d (sts_q), .q (sts_bus)
   );
endmodule

// File: rtl/smbn_notify_regs.sv
module smbn_notify_regs
   import smbn_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int NADDR_W     = 7,
   parameter int NDATA_W     = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic               bus_clk,
   input  logic               slow_clk,
   input  logic               rsm_rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic               scl_in,
   input  logic               sda_in,
   output logic               scl_force_low,
   input  logic               rx_notify_done,
   input  logic [NADDR_W-1:0] rx_notify_addr,
   input  logic [NDATA_W-1:0] rx_notify_data,
   output logic               rx_ack_en,
   output logic [NADDR_W-1:0] notify_addr,
   output logic [NDATA_W-1:0] notify_data
);
   localparam logic [ADDR_W-1:0] A_LINE   = ADDR_W'(OFS_LINE);
   localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);

   if (ADDR_W < 1) begin : g_bad_aw
      $error("smbn_notify_regs: ADDR_W must be at least 1");
   end
   if (NADDR_W < 1 || NADDR_W > 8) begin : g_bad_naw
      $error("smbn_notify_regs: NADDR_W must be 1..8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("smbn_notify_regs: SYNC_STAGES must be at least 2");
   end

   logic      hit_line, hit_status;
   reg_byte_t line_rd;
   logic      sts_bus, sts_q, clr_evt;
   logic      unused_wdata;

   assign hit_line     = (bus_addr == A_LINE);
   assign hit_status   = (bus_addr == A_STATUS);
   assign unused_wdata = ^{bus_wdata[7:3], bus_wdata[1]};

   smbn_line_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_line (
      .clk           (bus_clk),
      .rst_n         (rsm_rst_n),
      .wr_en         (bus_wr && hit_line),
      .wr_ovr_bit    (bus_wdata[BIT_CLK_OVR]),
      .scl_pin       (scl_in),
      .sda_pin       (sda_in),
      .rd_byte       (line_rd),
      .scl_force_low (scl_force_low)
   );

   smbn_notify_sts #(
      .SYNC_STAGES (SYNC_STAGES),
      .NADDR_W     (NADDR_W),
      .NDATA_W     (NDATA_W)
   ) u_sts (
      .bus_clk   (bus_clk),
      .slow_clk  (slow_clk),
      .rst_n     (rsm_rst_n),
      .clr_wr    (bus_wr && hit_status && bus_wdata[BIT_NOTIFIED]),
      .rx_done   (rx_notify_done),
      .rx_addr   (rx_notify_addr),
      .rx_data   (rx_notify_data),
      .sts_bus   (sts_bus),
      .sts_q     (sts_q),
      .clr_evt   (clr_evt),
      .ack_en    (rx_ack_en),
      .hold_addr (notify_addr),
      .hold_data (notify_data)
   );

   always_comb begin
      bus_rdata = '0;
      if (hit_line)        bus_rdata = line_rd;
      else if (hit_status) bus_rdata[BIT_NOTIFIED] = sts_bus;
   end
endmodule

// File: rtl/smbn_chk.sv
module smbn_chk #(
   parameter int ADDR_W  = 3,
   parameter int NADDR_W = 7,
   parameter int NDATA_W = 16
) (
   input logic               bus_clk,
   input logic               slow_clk,
   input logic               rsm_rst_n,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               ovr_wbit,
   input logic               scl_force_low,
   input logic               rx_notify_done,
   input logic               rx_ack_en,
   input logic [NADDR_W-1:0] notify_addr,
   input logic [NDATA_W-1:0] notify_data,
   input logic               sts_q,
   input logic               clr_evt
);
   localparam logic [ADDR_W-1:0] A_LINE = ADDR_W'(smbn_pkg::OFS_LINE);

   // R2: override write drives the line low on the next bus clock
   a_r2_force: assert property (@(posedge bus_clk) disable iff (!rsm_rst_n)
      (bus_wr && bus_addr == A_LINE && !ovr_wbit) |=> scl_force_low);
   a_r2_release: assert property (@(posedge bus_clk) disable iff (!rsm_rst_n)
      (bus_wr && bus_addr == A_LINE && ovr_wbit) |=> !scl_force_low);
   // R4 / R8: a completed notify always leaves the bit set
   a_r4_set: assert property (@(posedge slow_clk) disable iff (!rsm_rst_n)
      rx_notify_done |=> sts_q);
   // R5: sticky without a clear, cleared by a clear without a set
   a_r5_sticky: assert property (@(posedge slow_clk) disable iff (!rsm_rst_n)
      (sts_q && !clr_evt) |=> sts_q);
   a_r5_clear: assert property (@(posedge slow_clk) disable iff (!rsm_rst_n)
      (clr_evt && !rx_notify_done) |=> !sts_q);
   // R6: the receiver may not ACK while the bit is set
   a_r6_nack: assert property (@(posedge slow_clk) disable iff (!rsm_rst_n)
      sts_q |-> !rx_ack_en);
   // R7: held values frozen while the bit is set
   a_r7_hold: assert property (@(posedge slow_clk) disable iff (!rsm_rst_n)
      sts_q |=> ($stable(notify_addr) && $stable(notify_data)));
endmodule

bind smbn_notify_regs smbn_chk #(
   .ADDR_W  (ADDR_W),
   .NADDR_W (NADDR_W),
   .NDATA_W (NDATA_W)
) u_chk (
   .bus_clk        (bus_clk),
   .slow_clk       (slow_clk),
   .rsm_rst_n      (rsm_rst_n),
   .bus_wr         (bus_wr),
   .bus_addr       (bus_addr),
   .ovr_wbit       (bus_wdata[2]),
   .scl_force_low  (scl_force_low),
   .rx_notify_done (rx_notify_done),
   .rx_ack_en      (rx_ack_en),
   .notify_addr    (notify_addr),
   .notify_data    (notify_data),
   .sts_q          (sts_q),
   .clr_evt        (clr_evt)
);

// File: tb/smbn_notify_regs_bench.sv
`timescale 1ns/1ps
module smbn_notify_regs_bench;
   localparam int AW = 3;
   localparam int NAW = 7;
   localparam int NDW = 16;

   logic bus_clk = 1'b0, slow_clk = 1'b0, rsm_rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0, bus_rdata;
   logic scl_in = 1'b1, sda_in = 1'b1, scl_force_low;
   logic rx_notify_done = 1'b0;
   logic [NAW-1:0] rx_notify_addr = '0, notify_addr;
   logic [NDW-1:0] rx_notify_data = '0, notify_data;
   logic rx_ack_en;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #4  bus_clk  = ~bus_clk;    // 125 MHz
   always #28 slow_clk = ~slow_clk;

   smbn_notify_regs u_smbn_notify_regs (
      .bus_clk, .slow_clk, .rsm_rst_n, .bus_wr, .bus_addr, .bus_wdata,
      .bus_rdata, .scl_in, .sda_in, .scl_force_low, .rx_notify_done,
      .rx_notify_addr, .rx_notify_data, .rx_ack_en, .notify_addr, .notify_data
   );

   // {write data, expected line read, expected force} with sda=1, scl=0
   localparam logic [16:0] VEC [6] = '{
      {8'h00, 8'h02, 1'b1}, {8'hFF, 8'h06, 1'b0}, {8'hFB, 8'h02, 1'b1},
      {8'h04, 8'h06, 1'b0}, {8'hF8, 8'h02, 1'b1}, {8'h07, 8'h06, 1'b0}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge bus_clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge bus_clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d);
      @(negedge bus_clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic poll_status(input logic [7:0] want, output logic [7:0] got);
      got = 8'hxx;
      for (int i = 0; i < 400; i++) begin
         bus_read(3'd1, got);
         if (got === want) break;
      end
   endtask

   task automatic notify_pulse(input logic [NAW-1:0] a, input logic [NDW-1:0] d);
      @(negedge slow_clk);
      rx_notify_done = 1'b1; rx_notify_addr = a; rx_notify_data = d;
      @(negedge slow_clk);
      rx_notify_done = 1'b0;
   endtask

   task automatic summary();
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #150000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      logic [7:0] rd;
      int ack_seen;
      repeat (3) @(negedge slow_clk);
      rsm_rst_n = 1'b1;
      repeat (2) @(negedge bus_clk);

      // R1 reset state
      bus_read(3'd0, rd);  check("R1 line reg", rd, 8'h07);
      bus_read(3'd1, rd);  check("R1 status", rd, 8'h00);
      check("R1 force", scl_force_low, 1'b0);
      check("R1 ack_en", rx_ack_en, 1'b1);

      // R3 line readback through two flops
      @(negedge bus_clk); scl_in = 1'b0; sda_in = 1'b1;
      repeat (2) @(negedge bus_clk);
      bus_read(3'd0, rd);  check("R3 scl low", rd, 8'h06);

      // R2 table walk
      for (int k = 0; k < 6; k++) begin
         bus_write(3'd0, VEC[k][16:9]);
         check("R2 force", scl_force_low, VEC[k][0]);
         bus_read(3'd0, rd);
         check("R2/R3 line read", rd, VEC[k][8:1]);
      end

      @(negedge bus_clk); scl_in = 1'b1; sda_in = 1'b0;
      repeat (2) @(negedge bus_clk);
      bus_read(3'd0, rd);  check("R3 sda low", rd, 8'h05);
      sda_in = 1'b1;

      // R9 unmapped offsets
      bus_read(3'd2, rd);  check("R9 offset 2", rd, 8'h00);
      bus_read(3'd7, rd);  check("R9 offset 7", rd, 8'h00);

      // R4 / R6 / R7 first notify
      notify_pulse(7'h2A, 16'hBEEF);
      check("R6 ack_en low after set", rx_ack_en, 1'b0);
      check("R7 addr captured", notify_addr, 7'h2A);
      check("R7 data captured", notify_data, 16'hBEEF);
      poll_status(8'h01, rd); check("R4 status set", rd, 8'h01);

      // R7 notify while set is not captured
      notify_pulse(7'h11, 16'h1234);
      check("R7 addr protected", notify_addr, 7'h2A);
      check("R7 data protected", notify_data, 16'hBEEF);

      // R5 writing 0 to bit 0 has no effect
      bus_write(3'd1, 8'h00);
      bus_write(3'd1, 8'hFE);
      repeat (20) @(negedge slow_clk);
      bus_read(3'd1, rd);  check("R5 zero write ignored", rd, 8'h01);
      check("R6 ack_en still low", rx_ack_en, 1'b0);

      // R5 write 1 clears
      bus_write(3'd1, 8'h01);
      poll_status(8'h00, rd); check("R5 cleared", rd, 8'h00);
      check("R6 ack_en restored", rx_ack_en, 1'b1);

      // R7 capture allowed again
      notify_pulse(7'h11, 16'h1234);
      check("R7 recapture addr", notify_addr, 7'h11);
      check("R7 recapture data", notify_data, 16'h1234);
      poll_status(8'h01, rd); check("R4 set again", rd, 8'h01);

      // R8 set and clear in the same slow cycle: hold done across the clear
      @(negedge slow_clk);
      rx_notify_done = 1'b1; rx_notify_addr = 7'h55; rx_notify_data = 16'h0F0F;
      bus_write(3'd1, 8'h01);
      ack_seen = 0;
      for (int i = 0; i < 30; i++) begin
         @(negedge slow_clk);
         if (rx_ack_en) ack_seen++;
      end
      rx_notify_done = 1'b0;
      check("R8 ack_en never rose", ack_seen, 0);
      repeat (4) @(negedge slow_clk);
      bus_read(3'd1, rd);  check("R8 status kept", rd, 8'h01);
      check("R8 addr kept", notify_addr, 7'h11);

      // R5 final clear
      bus_write(3'd1, 8'hFF);
      poll_status(8'h00, rd); check("R5 final clear", rd, 8'h00);

      summary();
   end
endmodule